// File: doc/BRIEF.md
# Byte-Half Register File

This block holds eight 16-bit working registers. It has two independent read ports and one write port. The first four registers can also be reached as separate 8-bit halves, and those halves share storage with the 16-bit view. A datapath uses it to take two operands per cycle and write one result back. An access-width bit on each port chooses between the full 16-bit register and a single byte half.

In word mode the 3-bit selector picks register 0 to 7. In byte mode the same selector names a half:

- Selector bit 2 picks the high half (bits 15:8) or the low half (bits 7:0).
- Selector bits 1:0 pick one of registers 0 to 3.

A byte read returns the half in the low eight bits and clears the upper eight. A byte write always takes its value from the low eight bits of the write data. Reads are combinational from the stored state, so a read in the same cycle as a write sees the value from before that write. The reset is synchronous and active low, and it clears every register.

Top module: `regfile_bytehalf`

## Requirements
- R1: All eight registers (index 0 to 7) are independently writable and readable as 16-bit words, and every one of them can act as general storage.
- R2: With wr_en=1 and wr_byte=0, all 16 bits of wr_data go into register wr_sel, and reads show the new value from the cycle after the write edge.
- R3: In byte mode (width bit = 1), selector codes 0 to 3 address bits 7:0 of registers 0 to 3. Codes 4 to 7 address bits 15:8 of registers 0 to 3, so code 4+k is the high half of register k.
- R4: A byte write changes only the addressed half. The other half of the same register and every other register keep their values.
- R5: A byte-mode read returns the addressed half in bits 7:0 with bits 15:8 equal to zero.
- R6: A byte write stores wr_data[7:0] into the addressed half, whichever half that is, and wr_data[15:8] has no effect.
- R7: With wr_en=0, no register changes, whatever the values on wr_sel, wr_byte and wr_data.
- R8: A read of a location that is being written in the same cycle returns the value held before that write.
- R9: rst_n=0 at a rising clock edge clears all registers to zero. The stored values do not change before that edge.
- R10: The two read ports work independently. Each returns its own location and width at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_byte | input | 1 | Write width: 0 word, 1 byte half |
| wr_sel | input | 3 | Write register or byte-half selector |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| rd_a_sel | input | 3 | Read port A selector |
| rd_a_byte | input | 1 | Read port A width: 0 word, 1 byte half |
| rd_b_sel | input | 3 | Read port B selector |
| rd_b_byte | input | 1 | Read port B width: 0 word, 1 byte half |
| rd_a_data | output | 16 | Read port A value, zero-extended in byte mode |
| rd_b_data | output | 16 | Read port B value, zero-extended in byte mode |

## Verification
The hardest case to reach from the ports is a high-half byte write, followed by a word read of the same register, with different data already in the low half. Only that sequence shows that the byte came from the low lane of wr_data and landed in bits 15:8 without touching bits 7:0.

The stimulus first fills every register with a distinct word. It then writes all eight byte codes with data whose upper byte is a decoy. After each write it reads the register back on one port as a word and on the other port as a byte.

Two further cases each need the right inputs in a single cycle:

- Read-during-write and the edge behaviour of the synchronous reset are both checked in the same cycle as the stimulus.
- The sample point lies before the rising edge, so the bench sees the value from before the edge.

// File: rtl/rf_pkg.sv
// Shared definitions for the byte-half register file.
// Assumes selector bit SEL_W-1 picks the high half in byte mode.
package rf_pkg;
    typedef enum logic {
        WIDTH_WORD = 1'b0,
        WIDTH_BYTE = 1'b1
    } width_e;
endpackage

// File: rtl/rf_wr_decode.sv
// Write decoder: turns selector, width and enable into per-register
// low-half and high-half write strobes.
// Assumes NUM_REGS is twice the number of split registers (byte code space).
module rf_wr_decode #(
    parameter int NUM_REGS = 8,
    parameter int SEL_W    = $clog2(NUM_REGS)
) (
    input  logic                wr_en,
    input  logic                wr_byte,
    input  logic [SEL_W-1:0]    wr_sel,
    output logic [NUM_REGS-1:0] lo_we,
    output logic [NUM_REGS-1:0] hi_we
);
    import rf_pkg::*;

    width_e mode;
    assign mode = width_e'(wr_byte);

    // Derive half strobes: word mode hits both halves, byte mode one half.
    always_comb begin
        lo_we = '0;
        hi_we = '0;
        if (wr_en) begin
            if (mode == WIDTH_WORD) begin
                lo_we[wr_sel] = 1'b1;
                hi_we[wr_sel] = 1'b1;
            end else if (wr_sel[SEL_W-1]) begin
                hi_we[wr_sel[SEL_W-2:0]] = 1'b1;
            end else begin
                lo_we[wr_sel[SEL_W-2:0]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rf_cell.sv
// One register of the file, stored as two independently enabled halves.
// Assumes DATA_W is even; reset is synchronous and active low.
module rf_cell #(
    parameter int DATA_W = 16,
    parameter int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [HALF_W-1:0] lo_d,
    input  logic [HALF_W-1:0] hi_d,
    output logic [DATA_W-1:0] q
);
    // Update each half on its own strobe; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (lo_we) q[HALF_W-1:0]      <= lo_d;
            if (hi_we) q[DATA_W-1:HALF_W] <= hi_d;
        end
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> q == '0)
        else $error("register not cleared by reset");

    // R4
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_we |=> q[HALF_W-1:0] == $past(q[HALF_W-1:0]))
        else $error("low half changed without strobe");

    // R4
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_we |=> q[DATA_W-1:HALF_W] == $past(q[DATA_W-1:HALF_W]))
        else $error("high half changed without strobe");
endmodule

// File: rtl/rf_rd_port.sv
// Read multiplexer: selects a whole register, or one byte half of a
// split register zero-extended to full width. Purely combinational.
module rf_rd_port #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int SEL_W    = $clog2(NUM_REGS),
    parameter int HALF_W   = DATA_W / 2
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
    input  logic [SEL_W-1:0]                rd_sel,
    input  logic                            rd_byte,
    output logic [DATA_W-1:0]               rd_data
);
    import rf_pkg::*;

    width_e      mode;
    logic [DATA_W-1:0] split_word;

    assign mode       = width_e'(rd_byte);
    assign split_word = regs_q[rd_sel[SEL_W-2:0]];

    // Pick the word, or the addressed half padded with zeros.
    always_comb begin
        if (mode == WIDTH_WORD) begin
            rd_data = regs_q[rd_sel];
        end else if (rd_sel[SEL_W-1]) begin
            rd_data = {{HALF_W{1'b0}}, split_word[DATA_W-1:HALF_W]};
        end else begin
            rd_data = {{HALF_W{1'b0}}, split_word[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/regfile_bytehalf.sv
// Register file top: NUM_REGS words with two combinational read ports and
// one synchronous write port. The lower half of the register set can also be
// addressed as byte halves. Reads see pre-write state (no bypass).
module regfile_bytehalf #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_a_sel,
    input  logic              rd_a_byte,
    input  logic [2:0]        rd_b_sel,
    input  logic              rd_b_byte,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int SEL_W  = $clog2(NUM_REGS);
    localparam int HALF_W = DATA_W / 2;

    logic [NUM_REGS-1:0]             lo_we;
    logic [NUM_REGS-1:0]             hi_we;
    logic [HALF_W-1:0]               hi_src;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    rf_wr_decode #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) wr_dec_i (
        .wr_en  (wr_en),
        .wr_byte(wr_byte),
        .wr_sel (wr_sel[SEL_W-1:0]),
        .lo_we  (lo_we),
        .hi_we  (hi_we)
    );

    // High half takes the upper data lane for words, the low lane for bytes.
    assign hi_src = wr_byte ? wr_data[HALF_W-1:0] : wr_data[DATA_W-1:HALF_W];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        rf_cell #(.DATA_W(DATA_W), .HALF_W(HALF_W)) cell_i (
            .clk  (clk),
            .rst_n(rst_n),
            .lo_we(lo_we[i]),
            .hi_we(hi_we[i]),
            .lo_d (wr_data[HALF_W-1:0]),
            .hi_d (hi_src),
            .q    (regs_q[i])
        );
    end

    rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SEL_W(SEL_W), .HALF_W(HALF_W)) rd_a_i (
        .regs_q (regs_q),
        .rd_sel (rd_a_sel[SEL_W-1:0]),
        .rd_byte(rd_a_byte),
        .rd_data(rd_a_data)
    );

    rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SEL_W(SEL_W), .HALF_W(HALF_W)) rd_b_i (
        .regs_q (regs_q),
        .rd_sel (rd_b_sel[SEL_W-1:0]),
        .rd_byte(rd_b_byte),
        .rd_data(rd_b_data)
    );

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lo_we) && $onehot0(hi_we))
        else $error("more than one register strobed");

    // R7
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> $countones({lo_we, hi_we}) == 0)
        else $error("strobe without write enable");

    // R2
    word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte) |=> regs_q[$past(wr_sel[SEL_W-1:0])] == $past(wr_data))
        else $error("word write not stored");

    // R5
    byte_zext_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_byte |-> rd_a_data[DATA_W-1:HALF_W] == '0)
        else $error("port A byte read not zero-extended");

    // R5
    byte_zext_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_byte |-> rd_b_data[DATA_W-1:HALF_W] == '0)
        else $error("port B byte read not zero-extended");
endmodule

// File: tb/regfile_bytehalf_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task computes expected read values from a
// reference array and queues them; the monitor compares them 1 ns after
// the falling edge on which the stimulus was applied.
module regfile_bytehalf_tb_top;
    typedef struct {
        bit          port_b;
        logic [15:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_byte = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_a_sel = '0, rd_b_sel = '0;
    logic        rd_a_byte = 1'b0, rd_b_byte = 1'b0;
    logic [15:0] rd_a_data, rd_b_data;

    logic [15:0] mdl [8];
    exp_t        sb_q [$];
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    regfile_bytehalf dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_a_sel(rd_a_sel), .rd_a_byte(rd_a_byte),
        .rd_b_sel(rd_b_sel), .rd_b_byte(rd_b_byte),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
    );

    // Expected read value under the selector encoding of R3 and R5.
    function automatic logic [15:0] exp_rd(input logic [2:0] s, input bit b);
        if (!b)        return mdl[s];
        else if (s[2]) return {8'h00, mdl[s[1:0]][15:8]};
        else           return {8'h00, mdl[s[1:0]][7:0]};
    endfunction

    // One cycle: drive inputs, queue both reads, then apply write/reset to model.
    task automatic cyc(input bit rst, input bit we, input bit wb,
                       input logic [2:0] ws, input logic [15:0] wd,
                       input logic [2:0] as, input bit ab,
                       input logic [2:0] bs, input bit bb, input string tag);
        exp_t e;
        rst_n = !rst; wr_en = we; wr_byte = wb; wr_sel = ws; wr_data = wd;
        rd_a_sel = as; rd_a_byte = ab; rd_b_sel = bs; rd_b_byte = bb;
        e.port_b = 1'b0; e.val = exp_rd(as, ab); e.tag = tag; sb_q.push_back(e);
        e.port_b = 1'b1; e.val = exp_rd(bs, bb); e.tag = tag; sb_q.push_back(e);
        @(negedge clk);
        if (rst) begin
            for (int k = 0; k < 8; k++) mdl[k] = '0;
        end else if (we) begin
            if (!wb)        mdl[ws] = wd;
            else if (ws[2]) mdl[ws[1:0]][15:8] = wd[7:0];
            else            mdl[ws[1:0]][7:0]  = wd[7:0];
        end
    endtask

    task automatic rd(input logic [2:0] as, input bit ab,
                      input logic [2:0] bs, input bit bb, input string tag);
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 16'h0, as, ab, bs, bb, tag);
    endtask

    // Monitor: pop and compare everything queued for this cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                logic [15:0] act;
                e = sb_q.pop_front();
                act = e.port_b ? rd_b_data : rd_a_data;
                n_run++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s port %s: actual %h expected %h",
                             e.tag, e.port_b ? "B" : "A", act, e.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) mdl[k] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R9: state after reset is zero in every register
        for (int k = 0; k < 8; k += 2) rd(3'(k), 1'b0, 3'(k + 1), 1'b0, "R9");

        // R1 R2: distinct word in each register, read back both ports
        for (int k = 0; k < 8; k++)
            cyc(1'b0, 1'b1, 1'b0, 3'(k), 16'h1111 * 16'(k + 1) ^ 16'h0A50,
                3'd0, 1'b0, 3'd0, 1'b0, "R2");
        for (int k = 0; k < 8; k++) rd(3'(k), 1'b0, 3'(7 - k), 1'b0, "R1");

        // R3 R5: every byte code read against the word contents
        for (int k = 0; k < 8; k++) rd(3'(k), 1'b1, 3'(k & 3), 1'b0, "R3");

        // R4 R6: byte writes on all codes with a decoy upper data byte
        for (int k = 0; k < 8; k++) begin
            cyc(1'b0, 1'b1, 1'b1, 3'(k), {8'hEE, 8'(8'h31 + k * 8'h13)},
                3'd0, 1'b0, 3'd0, 1'b0, "R6");
            rd(3'(k & 3), 1'b0, 3'(k), 1'b1, "R4");
            rd(3'((k + 1) & 3), 1'b0, 3'(4 + (k & 3)), 1'b0, "R4");
        end
        for (int k = 0; k < 8; k += 2) rd(3'(k), 1'b0, 3'(k + 1), 1'b0, "R4");

        // R5: byte reads of high halves have zero upper bits
        rd(3'd4, 1'b1, 3'd7, 1'b1, "R5");

        // R7: disabled write with busy inputs changes nothing
        wr_en = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 3'd5, 16'hDEAD, 3'd5, 1'b0, 3'd1, 1'b0, "R7");
        cyc(1'b0, 1'b0, 1'b0, 3'd2, 16'hBEEF, 3'd2, 1'b0, 3'd5, 1'b1, "R7");
        rd(3'd2, 1'b0, 3'd5, 1'b0, "R7");
        rd(3'd1, 1'b0, 3'd5, 1'b1, "R7");

        // R8: read of location being written returns old value
        cyc(1'b0, 1'b1, 1'b0, 3'd6, 16'h6E6E, 3'd6, 1'b0, 3'd6, 1'b0, "R8");
        cyc(1'b0, 1'b1, 1'b1, 3'd4, 16'h00C4, 3'd4, 1'b1, 3'd0, 1'b0, "R8");
        rd(3'd6, 1'b0, 3'd0, 1'b0, "R8");

        // R10: ports with different widths and targets in the same cycle
        rd(3'd3, 1'b1, 3'd7, 1'b0, "R10");
        rd(3'd5, 1'b0, 3'd6, 1'b1, "R10");

        // R9: reset takes effect at the edge; before it, old values remain
        cyc(1'b1, 1'b1, 1'b0, 3'd3, 16'h5A5A, 3'd3, 1'b0, 3'd7, 1'b0, "R9");
        rst_n = 1'b1;
        for (int k = 0; k < 8; k += 2) rd(3'(k), 1'b0, 3'(k + 1), 1'b0, "R9");

        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule